// File: doc/BRIEF.md
# Paging Receiver Power Sequencer

This block decides when the radio front end of a battery-powered paging receiver is powered. It drives three power controls: a receiver supply enable, a quick-charge strobe that runs only in the short lead before a receive window, and a synthesizer enable that can start earlier than the receiver. Time is measured in bit periods, counted from a one-cycle bit tick. A second, slower tick measures the long out-of-range hold.

When enabled, the block keeps the receiver on for four 576-bit batches. It then switches to one-third duty (192 of every 576 bits) for a programmable odd number of batches. After that it falls back to a narrow idle window once per batch. A sync pulse from the correlator moves it to the locked phase, where it powers a short window each batch. If sync stays absent for the hold time, the search starts again. A preamble pulse during the duty-cycled or idle search restarts the continuous search. A test flag held together with the enable keeps the receiver and synthesizer on for bench adjustment. Each power output has its own polarity option.

Top module: `page_pwr_seq`

## Requirements
- R1: When enable is high, test is low and the mode is off or test, the next cycle the block enters continuous search (mode 1). Receiver and synthesizer are on and charge is off. After 4×576 bit ticks it moves to duty search (mode 2).
- R2: In duty search the phase counts bit ticks from 0 at entry, modulo 576. The receiver window covers phases 0 to 191.
- R3: Duty search lasts N batches, N = 2·{~code[2], code[1], code[0]} + 1, where code is `retry_code_i`. After that the block moves to idle search (mode 3).
- R4: In idle search the window covers phases 0 to 31, or 0 to 63 when `wide_idle_i` is 1. In lock the window covers phases 0 to 31.
- R5: Receiver and charge turn on at phase 576−L, with L = 2+4·`rf_lead_sel_i`. Charge is high only in that lead. The synthesizer also turns on at phase 576−L−16·`pll_extra_sel_i`.
- R6: A sync pulse in any search mode puts the block in lock (mode 4) in the next cycle, even when a stage ends in the same cycle. `in_range_o` is 1 only in lock.
- R7: A preamble pulse in duty or idle search restarts continuous search.
- R8: In lock, hold-tick pulses are counted from entry or from the last sync pulse. When the count reaches the limit, the block returns to continuous search. The limit is 36/72/144/288 for `hold_sel_i` 0..3, or 31/61/123/246 when `fast_rate_i` is 1.
- R9: With `hold_zero_i` set, a lock batch (576 ticks) that ends with no sync pulse since the previous batch end returns the block to continuous search. The sync pulse that caused entry counts for the first batch.
- R10: Enable low forces off (mode 0) in the next cycle, over any other event. In off mode all three power controls are inactive.
- R11: Test high with enable high gives test mode (mode 5): receiver and synthesizer on, charge off. Enable low then gives off.
- R12: `pol_inv_i` bit 0, 1 and 2 invert the receiver, charge and synthesizer outputs respectively.
- R13: Reset (synchronous, active low) gives mode 0 and inactive controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Receive enable |
| test_i | input | 1 | Reset-held test flag |
| bit_tick_i | input | 1 | One pulse per bit period |
| hold_tick_i | input | 1 | Slow pulse for the out-of-range hold |
| pre_det_i | input | 1 | Preamble found pulse |
| sync_det_i | input | 1 | Sync codeword found pulse |
| rf_lead_sel_i | input | 2 | Receiver lead select |
| pll_extra_sel_i | input | 2 | Extra synthesizer lead select |
| retry_code_i | input | 3 | Duty search batch count code |
| wide_idle_i | input | 1 | Doubles the idle window |
| hold_sel_i | input | 2 | Hold time select |
| hold_zero_i | input | 1 | Zero hold: leave lock at first batch without sync |
| fast_rate_i | input | 1 | Selects the shorter hold table |
| pol_inv_i | input | 3 | Output polarity inversions |
| rf_en_o | output | 1 | Receiver power enable |
| chg_o | output | 1 | Receiver quick-charge strobe |
| pll_en_o | output | 1 | Synthesizer power enable |
| in_range_o | output | 1 | High while locked |
| mode_o | output | 3 | Current mode code |

## Verification
A sync pulse can arrive in the same cycle as the bit tick that ends the last duty batch. That tick alone would move the block to idle search, so the pulse must take priority. The bench drives both in one cycle and expects lock and `in_range_o` high in the next cycle. It also raises sync in the cycle that enable falls, and expects off to win. Random configurations exercise the stage lengths and the lead edges around the conflicts.

// File: rtl/page_pwr_pkg.sv
`timescale 1ns/1ps
// Shared mode codes and the out-of-range hold table.
// Assumes hold limits fit in 9 bits.
package page_pwr_pkg;

    typedef enum logic [2:0] {
        MD_OFF  = 3'd0,
        MD_CONT = 3'd1,
        MD_DUTY = 3'd2,
        MD_IDLE = 3'd3,
        MD_LOCK = 3'd4,
        MD_TEST = 3'd5
    } mode_e;

    localparam int HOLD_W = 9;

    // Hold limit in slow ticks: slow-rate table or fast-rate table.
    function automatic logic [HOLD_W-1:0] hold_limit(input logic [1:0] sel, input logic fast);
        logic [HOLD_W-1:0] v;
        case ({fast, sel})
            3'b000:  v = 9'd36;
            3'b001:  v = 9'd72;
            3'b010:  v = 9'd144;
            3'b011:  v = 9'd288;
            3'b100:  v = 9'd31;
            3'b101:  v = 9'd61;
            3'b110:  v = 9'd123;
            default: v = 9'd246;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/page_pwr_timer.sv
`timescale 1ns/1ps
// Bit-period phase counter and batch counter.
// Phase runs 0..BATCH_BITS-1 on bit ticks; a wrap bumps the batch count.
// Assumes clr_i is raised whenever the mode changes.
module page_pwr_timer #(
    parameter int BATCH_BITS = 576,
    parameter int CNT_W      = 4,
    localparam int PH_W      = $clog2(BATCH_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [PH_W-1:0]  phase_o,
    output logic [CNT_W-1:0] batch_o,
    output logic             wrap_o
);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(BATCH_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [PH_W-1:0]  phase_q;
    logic [CNT_W-1:0] batch_q;

    assign wrap_o  = tick_i && (phase_q == PH_LAST);
    assign phase_o = phase_q;
    assign batch_o = batch_q;

    // Phase and batch advance; cleared on reset or mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            phase_q <= '0;
            batch_q <= '0;
        end else if (tick_i) begin
            if (wrap_o) begin
                phase_q <= '0;
                if (batch_q != CNT_MAX) batch_q <= batch_q + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < PH_W'(BATCH_BITS));
    // R13
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (phase_o == '0 && batch_o == '0));

endmodule

// File: rtl/page_pwr_window.sv
`timescale 1ns/1ps
// Turns mode and phase into raw (active-high) power controls.
// Window starts at phase 0; leads sit at the end of the previous period.
// Assumes total lead plus window is shorter than one batch.
module page_pwr_window #(
    parameter int BATCH_BITS   = 576,
    parameter int DUTY_BITS    = 192,
    parameter int IDLE_BITS    = 32,
    parameter int LOCK_BITS    = 32,
    parameter int RF_LEAD_BASE = 2,
    parameter int RF_LEAD_STEP = 4,
    parameter int PLL_STEP     = 16,
    localparam int PH_W        = $clog2(BATCH_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  page_pwr_pkg::mode_e mode_i,
    input  logic [PH_W-1:0]   phase_i,
    input  logic              wide_idle_i,
    input  logic [1:0]        rf_lead_sel_i,
    input  logic [1:0]        pll_extra_sel_i,
    output logic [2:0]        raw_o
);
    import page_pwr_pkg::*;

    logic [PH_W-1:0] lead, extra, rf_start, pll_start, win;
    logic            rf_raw, chg_raw, pll_raw, in_lead;

    // Lead lengths and window size for the current mode.
    always_comb begin
        lead      = PH_W'(RF_LEAD_BASE) + PH_W'(rf_lead_sel_i) * PH_W'(RF_LEAD_STEP);
        extra     = PH_W'(pll_extra_sel_i) * PH_W'(PLL_STEP);
        rf_start  = PH_W'(BATCH_BITS) - lead;
        pll_start = rf_start - extra;
        case (mode_i)
            MD_DUTY: win = PH_W'(DUTY_BITS);
            MD_IDLE: win = wide_idle_i ? PH_W'(2 * IDLE_BITS) : PH_W'(IDLE_BITS);
            default: win = PH_W'(LOCK_BITS);
        endcase
    end

    // Per-mode raw control levels.
    always_comb begin
        in_lead = phase_i >= rf_start;
        case (mode_i)
            MD_CONT, MD_TEST: begin
                rf_raw = 1'b1; chg_raw = 1'b0; pll_raw = 1'b1;
            end
            MD_DUTY, MD_IDLE, MD_LOCK: begin
                chg_raw = in_lead;
                rf_raw  = (phase_i < win) || in_lead;
                pll_raw = rf_raw || (phase_i >= pll_start);
            end
            default: begin
                rf_raw = 1'b0; chg_raw = 1'b0; pll_raw = 1'b0;
            end
        endcase
    end

    assign raw_o = {pll_raw, chg_raw, rf_raw};

    // R5
    chg_in_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_raw |-> (rf_raw && pll_raw));
    // R11
    test_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_TEST) |-> (rf_raw && pll_raw && !chg_raw));

endmodule

// File: rtl/page_pwr_hold.sv
`timescale 1ns/1ps
// Out-of-range hold counter for lock mode.
// Counts slow ticks since entry or the last sync; flags expiry on the tick that hits the limit.
// Assumes limit_i is stable while run_i is high and never below 2.
module page_pwr_hold #(
    parameter int HW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          restart_i,
    input  logic          tick_i,
    input  logic [HW-1:0] limit_i,
    output logic          expire_o
);
    logic [HW-1:0] cnt_q;

    assign expire_o = run_i && !restart_i && tick_i && (cnt_q == limit_i - 1'b1);

    // Tick counter, cleared outside lock and on every sync.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) cnt_q <= '0;
        else if (tick_i)                   cnt_q <= cnt_q + 1'b1;
    end

    // R8
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/page_pwr_seq.sv
`timescale 1ns/1ps
// Power sequencer for a paging receiver: continuous search, duty search,
// idle search and lock, with polarity-selectable receiver, charge and
// synthesizer controls. Assumes all inputs are synchronous to clk.
module page_pwr_seq #(
    parameter int BATCH_BITS   = 576,
    parameter int CONT_BATCHES = 4,
    parameter int DUTY_BITS    = 192,
    parameter int IDLE_BITS    = 32,
    parameter int LOCK_BITS    = 32,
    parameter int CNT_W        = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       test_i,
    input  logic       bit_tick_i,
    input  logic       hold_tick_i,
    input  logic       pre_det_i,
    input  logic       sync_det_i,
    input  logic [1:0] rf_lead_sel_i,
    input  logic [1:0] pll_extra_sel_i,
    input  logic [2:0] retry_code_i,
    input  logic       wide_idle_i,
    input  logic [1:0] hold_sel_i,
    input  logic       hold_zero_i,
    input  logic       fast_rate_i,
    input  logic [2:0] pol_inv_i,
    output logic       rf_en_o,
    output logic       chg_o,
    output logic       pll_en_o,
    output logic       in_range_o,
    output logic [2:0] mode_o
);
    import page_pwr_pkg::*;

    localparam int PH_W = $clog2(BATCH_BITS);

    mode_e            state_q, state_d;
    logic [PH_W-1:0]  phase;
    logic [CNT_W-1:0] batch, retry_n;
    logic             wrap, clr, hold_exp, zero_exp, seen_q;
    logic [2:0]       raw;

    // Duty batch count from the retry code.
    assign retry_n = CNT_W'({~retry_code_i[2], retry_code_i[1:0]}) * CNT_W'(2) + CNT_W'(1);

    assign zero_exp = (state_q == MD_LOCK) && hold_zero_i && wrap && !seen_q && !sync_det_i;

    // Next mode, highest priority first.
    always_comb begin
        state_d = state_q;
        if (test_i)                                        state_d = en_i ? MD_TEST : MD_OFF;
        else if (!en_i)                                    state_d = MD_OFF;
        else if (state_q == MD_OFF || state_q == MD_TEST)  state_d = MD_CONT;
        else if (sync_det_i)                               state_d = MD_LOCK;
        else if (pre_det_i && (state_q == MD_DUTY || state_q == MD_IDLE)) state_d = MD_CONT;
        else begin
            case (state_q)
                MD_CONT: if (wrap && batch == CNT_W'(CONT_BATCHES - 1)) state_d = MD_DUTY;
                MD_DUTY: if (wrap && batch == retry_n - 1'b1)           state_d = MD_IDLE;
                MD_LOCK: if (hold_exp || zero_exp)                      state_d = MD_CONT;
                default: ;
            endcase
        end
    end

    assign clr = (state_d != state_q) || (state_q == MD_OFF);

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MD_OFF;
        else        state_q <= state_d;
    end

    // Sync-seen-this-batch flag for the zero-hold exit.
    always_ff @(posedge clk) begin
        if (!rst_n || state_d != MD_LOCK) seen_q <= 1'b0;
        else                              seen_q <= (seen_q && !wrap) || sync_det_i;
    end

    page_pwr_timer #(.BATCH_BITS(BATCH_BITS), .CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(bit_tick_i),
        .phase_o(phase), .batch_o(batch), .wrap_o(wrap)
    );

    page_pwr_window #(.BATCH_BITS(BATCH_BITS), .DUTY_BITS(DUTY_BITS),
                      .IDLE_BITS(IDLE_BITS), .LOCK_BITS(LOCK_BITS)) window_i (
        .clk(clk), .rst_n(rst_n), .mode_i(state_q), .phase_i(phase),
        .wide_idle_i(wide_idle_i), .rf_lead_sel_i(rf_lead_sel_i),
        .pll_extra_sel_i(pll_extra_sel_i), .raw_o(raw)
    );

    page_pwr_hold #(.HW(HOLD_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .run_i(state_q == MD_LOCK), .restart_i(sync_det_i),
        .tick_i(hold_tick_i), .limit_i(hold_limit(hold_sel_i, fast_rate_i)),
        .expire_o(hold_exp)
    );

    // Per-output polarity.
    logic [2:0] pin;
    for (genvar i = 0; i < 3; i++) begin : g_pol
        assign pin[i] = raw[i] ^ pol_inv_i[i];
    end

    assign rf_en_o    = pin[0];
    assign chg_o      = pin[1];
    assign pll_en_o   = pin[2];
    assign in_range_o = (state_q == MD_LOCK);
    assign mode_o     = state_q;

    // R10
    off_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (mode_o == 3'd0 && !in_range_o));
    // R6
    sync_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !test_i && sync_det_i && state_q != MD_OFF && state_q != MD_TEST) |=> in_range_o);
    // R1
    cont_batches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_CONT) |-> (batch < CNT_W'(CONT_BATCHES)));

endmodule

// File: tb/page_pwr_seq_tb.sv
`timescale 1ns/1ps
module page_pwr_seq_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 0, test = 0, btick = 0, htick = 0, pre = 0, sync = 0;
    logic [1:0] lsel = 0, esel = 0, hsel = 0;
    logic [2:0] code = 0, pol = 0;
    logic wide = 0, hzero = 0, fast = 0;
    logic rf, chg, pll, inr;
    logic [2:0] mode;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    page_pwr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .test_i(test), .bit_tick_i(btick),
        .hold_tick_i(htick), .pre_det_i(pre), .sync_det_i(sync),
        .rf_lead_sel_i(lsel), .pll_extra_sel_i(esel), .retry_code_i(code),
        .wide_idle_i(wide), .hold_sel_i(hsel), .hold_zero_i(hzero),
        .fast_rate_i(fast), .pol_inv_i(pol), .rf_en_o(rf), .chg_o(chg),
        .pll_en_o(pll), .in_range_o(inr), .mode_o(mode)
    );

    task automatic cyc(); @(posedge clk); #1; endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin btick = 1; cyc(); btick = 0; cyc(); end
    endtask
    task automatic hticks(input int n);
        for (int i = 0; i < n; i++) begin htick = 1; cyc(); htick = 0; cyc(); end
    endtask
    task automatic pulse_sync(); sync = 1; cyc(); sync = 0; endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected {pll,chg,rf} before polarity, from the window rules.
    function automatic logic [2:0] exp_pwr(int m, int p, int w, int lead, int extra);
        logic r, c, q;
        if (m == 1 || m == 5) return 3'b101;
        if (m == 0) return 3'b000;
        c = p >= 576 - lead;
        r = (p < w) || c;
        q = r || (p >= 576 - lead - extra);
        return {q, c, r};
    endfunction

    task automatic chk_pwr(input string req, input int m, input int p, input int w,
                           input int lead, input int extra);
        logic [2:0] e;
        e = exp_pwr(m, p, w, lead, extra) ^ pol;
        chk({req, " mode"}, mode, m);
        chk({req, " rf"}, rf, e[0]);
        chk({req, " chg"}, chg, e[1]);
        chk({req, " pll"}, pll, e[2]);
    endtask

    function automatic int retries(logic [2:0] c);
        return 2 * ((c[2] ? 0 : 4) + int'(c[1:0])) + 1;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        cyc(); cyc(); rst_n = 1; cyc();
        // R13 reset state
        chk_pwr("R13", 0, 0, 0, 0, 0);

        // Directed: lead 6, extra 16, one duty batch
        lsel = 1; esel = 1; code = 3'b100;
        en = 1; cyc();
        chk_pwr("R1", 1, 0, 0, 6, 16);
        ticks(2303); chk("R1 still continuous", mode, 1);
        ticks(1);    chk_pwr("R2", 2, 0, 192, 6, 16);
        ticks(191);  chk_pwr("R2", 2, 191, 192, 6, 16);
        ticks(1);    chk_pwr("R2", 2, 192, 192, 6, 16);
        ticks(361);  chk_pwr("R5", 2, 553, 192, 6, 16);
        ticks(1);    chk_pwr("R5", 2, 554, 192, 6, 16);
        ticks(15);   chk_pwr("R5", 2, 569, 192, 6, 16);
        ticks(1);    chk_pwr("R5", 2, 570, 192, 6, 16);
        ticks(5);    chk("R3 last duty tick", mode, 2);
        ticks(1);    chk_pwr("R3", 3, 0, 32, 6, 16);
        ticks(31);   chk_pwr("R4", 3, 31, 32, 6, 16);
        ticks(1);    chk_pwr("R4", 3, 32, 32, 6, 16);
        pre = 1; cyc(); pre = 0;
        chk("R7 preamble restarts", mode, 1);

        // R6 conflict: sync on the tick ending the last duty batch
        ticks(2304); chk("R1 to duty", mode, 2);
        ticks(575);
        btick = 1; sync = 1; cyc(); btick = 0; sync = 0;
        chk("R6 sync beats stage end", mode, 4);
        chk("R6 in range", inr, 1);
        chk_pwr("R4 lock window", 4, 0, 32, 6, 16);

        // R8 hold expiry
        hticks(35); chk("R8 before limit", mode, 4);
        hticks(1);  chk("R8 at limit", mode, 1);
        chk("R6 out of range", inr, 0);
        pulse_sync(); chk("R6 lock from continuous", mode, 4);
        hticks(20); pulse_sync(); hticks(35);
        chk("R8 sync restarts hold", mode, 4);
        hticks(1);  chk("R8 restarted limit", mode, 1);
        fast = 1; hsel = 1;
        pulse_sync(); hticks(60); chk("R8 fast table", mode, 4);
        hticks(1);  chk("R8 fast limit", mode, 1);
        fast = 0; hsel = 0;

        // R9 zero hold
        hzero = 1;
        pulse_sync(); ticks(1151); chk("R9 first batch covered", mode, 4);
        ticks(1);     chk("R9 empty batch exits", mode, 1);
        hzero = 0;

        // R10 disable beats sync
        pulse_sync();
        en = 0; sync = 1; cyc(); sync = 0;
        chk_pwr("R10", 0, 0, 0, 6, 16);

        // R11 test mode
        test = 1; en = 1; cyc(); chk_pwr("R11", 5, 0, 0, 6, 16);
        ticks(700); chk_pwr("R11 held", 5, 0, 0, 6, 16);
        en = 0; cyc(); chk_pwr("R11 exit", 0, 0, 0, 6, 16);
        test = 0;

        // R12 polarity
        pol = 3'b111; cyc(); chk_pwr("R12", 0, 0, 0, 6, 16);
        en = 1; cyc(); chk_pwr("R12", 1, 0, 0, 6, 16);
        pol = 3'b010; cyc(); chk_pwr("R12", 1, 0, 0, 6, 16);
        pol = 0; en = 0; cyc();

        // Random configurations through the full search
        for (int it = 0; it < 4; it++) begin
            int lead, extra, w, cur;
            int pl[6];
            lsel = 2'($urandom % 4); esel = 2'($urandom % 4);
            code = 3'($urandom % 8); wide = 1'($urandom % 2);
            lead = 2 + 4 * int'(lsel); extra = 16 * int'(esel); w = wide ? 64 : 32;
            en = 0; cyc(); chk("R10 off", mode, 0);
            en = 1; cyc(); chk("R1 start", mode, 1);
            ticks(2304); chk("R1 end", mode, 2);
            ticks(retries(code) * 576 - 1); chk("R3 duty length", mode, 2);
            ticks(1); chk("R3 idle entry", mode, 3);
            pl = '{w - 1, w, 575 - lead - extra, 576 - lead - extra, 575 - lead, 576 - lead};
            cur = 0;
            foreach (pl[k]) begin
                if (pl[k] >= cur) begin
                    ticks(pl[k] - cur); cur = pl[k];
                    chk_pwr((k < 2) ? "R4" : "R5", 3, cur, w, lead, extra);
                end
            end
        end
        en = 0; cyc();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule